// File: doc/BRIEF.md
# Lane-Selectable Carry-Less Multiplier

This block multiplies pairs of 64-bit binary polynomials over GF(2) and returns each full 128-bit product. Two 512-bit source words are viewed as four 128-bit lanes of two 64-bit quadwords each. One, two or four lanes are active, and every active lane forms its own product in parallel. An 8-bit immediate picks, for each source separately, whether the low or the high quadword of each lane is the multiplicand. The field reduction used by authentication hashes is left to the logic downstream. The products are raw.

A request is taken when `start` is high while the unit is idle. The sources, the immediate and the lane select are latched on that edge, and need not be held afterwards. Each lane then consumes one multiplier bit per cycle. After 64 such steps, `valid` pulses for one cycle, and `result` carries all lane products. `result` keeps its value until the next completion. With one lane active, the unit behaves like a plain single 64x64 carry-less multiply that returns a 128-bit product.

Top module: `lsel_clmul`

## Requirements
- R1: In lane i, the first multiplicand is quadword 2i+imm[0] of `src_a`, where quadword q occupies bits [64q+63:64q].
- R2: In lane i, the second multiplicand is quadword 2i+imm[4] of `src_b`. This choice is independent of imm[0].
- R3: Each lane product is the carry-less (XOR-combined) product, placed in `result` bits [128i+127:128i]. For example, 3 times 3 gives 5, not 9.
- R4: `lane_sel` 2'b00 activates lane 0, 2'b01 activates lanes 0-1, and 2'b10 or 2'b11 activates all four lanes. The result bits of inactive lanes read zero.
- R5: Immediate bits other than bit 0 and bit 4 have no effect on the result.
- R6: Bit 127 of every lane product is zero.
- R7: `valid` rises exactly 64 clock edges after the edge that accepted `start`. It is one cycle wide. `busy` is high from the edge after acceptance until the completion edge, and `busy` is low while `valid` is high.
- R8: A `start` that arrives while `busy` is high is ignored and produces no extra completion. `result` changes only on the edge where `valid` rises.
- R9: While `rst_n` is low and after it is released, `busy`, `valid` and `result` are zero until the first request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; taken only while idle |
| lane_sel | input | 2 | Number of active lanes (see R4) |
| imm | input | 8 | Quadword selector; bit 0 applies to `src_a`, bit 4 to `src_b` |
| src_a | input | 512 | First source, four 128-bit lanes |
| src_b | input | 512 | Second source, four 128-bit lanes |
| busy | output | 1 | Multiplication in progress |
| valid | output | 1 | One-cycle completion pulse |
| result | output | 512 | Lane products, held until the next completion |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of an iteration. The unit must drop it, keep the first operands, and neither corrupt the result nor raise an extra pulse. The stimulus drives `start` with different operands while `busy` is high. The scoreboard is not told about that request, so any spurious completion or changed product shows up as a mismatch or as an unexpected pulse. To separate the two select bits, each lane is loaded with four distinct quadwords, all four selections are swept, and the immediate is also driven with its other bits set.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [1:0] {
    LS_ONE   = 2'b00,
    LS_TWO   = 2'b01,
    LS_FOUR  = 2'b10,
    LS_FOURX = 2'b11
  } lane_sel_e;

  // R4: which lanes participate for a given lane count selection
  function automatic logic lane_active(input logic [1:0] sel, input int lane);
    case (lane_sel_e'(sel))
      LS_ONE:  return lane == 0;
      LS_TWO:  return lane < 2;
      default: return 1'b1;
    endcase
  endfunction

  // one shift-and-add step over GF(2): XOR in the shifted multiplicand when the bit is set
  function automatic logic [127:0] gf2_step(input logic [127:0] acc,
                                            input logic [127:0] a_sh,
                                            input logic         b_bit);
    return acc ^ (b_bit ? a_sh : 128'd0);
  endfunction

endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl #(
  parameter int STEPS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign step   = busy;
  assign finish = busy && (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/lsc_lane.sv
module lsc_lane #(
  parameter int QW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [QW-1:0]   a_in,
  input  logic [QW-1:0]   b_in,
  output logic [2*QW-1:0] prod_nx
);
  localparam int LW = 2 * QW;

  logic [LW-1:0] a_sh;
  logic [QW-1:0] b_sh;
  logic [LW-1:0] acc;

  assign prod_nx = lsc_pkg::gf2_step(acc, a_sh, b_sh[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
      acc  <= '0;
    end else if (load) begin
      a_sh <= {{QW{1'b0}}, a_in};
      b_sh <= b_in;
      acc  <= '0;
    end else if (step) begin
      acc  <= prod_nx;
      a_sh <= a_sh << 1;
      b_sh <= b_sh >> 1;
    end
  end
endmodule

// File: rtl/lsel_clmul.sv
module lsel_clmul #(
  parameter int QW    = 64,
  parameter int NLANE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               lane_sel,
  input  logic [7:0]               imm,
  input  logic [NLANE*2*QW-1:0]    src_a,
  input  logic [NLANE*2*QW-1:0]    src_b,
  output logic                     busy,
  output logic                     valid,
  output logic [NLANE*2*QW-1:0]    result
);
  localparam int LW = 2 * QW;
  localparam int BW = NLANE * LW;

  logic          accept;
  logic          step;
  logic          finish;
  logic [BW-1:0] prod_all;

  lsc_ctrl #(.STEPS(QW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .step(step), .finish(finish), .busy(busy)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic          on;
    logic [QW-1:0] a_pick;
    logic [QW-1:0] b_pick;

    assign on     = lsc_pkg::lane_active(lane_sel, g);
    assign a_pick = on ? src_a[g*LW + (imm[0] ? QW : 0) +: QW] : '0;
    assign b_pick = on ? src_b[g*LW + (imm[4] ? QW : 0) +: QW] : '0;

    lsc_lane #(.QW(QW)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
      .a_in(a_pick), .b_in(b_pick), .prod_nx(prod_all[g*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      result <= '0;
    end else begin
      valid <= finish;
      if (finish) result <= prod_all;
    end
  end
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int STEPS = 64,
  parameter int NLANE = 4,
  parameter int LW    = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                accept,
  input logic                busy,
  input logic                valid,
  input logic [1:0]          lane_sel,
  input logic [NLANE*LW-1:0] result
);
  localparam int NW = $clog2(STEPS + 2);

  logic [NW-1:0] n;
  logic          run;
  logic [1:0]    sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n <= '0; run <= 1'b0; sel_q <= 2'b00;
    end else if (accept) begin
      n <= '0; run <= 1'b1; sel_q <= lane_sel;
    end else if (run) begin
      n <= n + 1'b1;
      if (valid) run <= 1'b0;
    end
  end

  function automatic logic tops_clear(input logic [NLANE*LW-1:0] r);
    logic z = 1'b1;
    for (int i = 0; i < NLANE; i++) z &= !r[i*LW + LW - 1];
    return z;
  endfunction

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (run && n == NW'(STEPS)));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_busy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));
  assert_no_early_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && n < NW'(STEPS - 1)) |=> busy);
  assert_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> tops_clear(result));
  assert_idle_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sel_q == 2'b00) |-> (result[NLANE*LW-1:LW] == '0));
  assert_idle_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sel_q == 2'b01) |-> (result[NLANE*LW-1:2*LW] == '0));
endmodule

bind lsel_clmul lsc_chk #(.STEPS(QW), .NLANE(NLANE), .LW(2*QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .valid(valid),
  .lane_sel(lane_sel), .result(result)
);

// File: tb/sim_lsel_clmul.sv
module sim_lsel_clmul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   lane_sel = 2'b00;
  logic [7:0]   imm = 8'h00;
  logic [511:0] src_a = '0;
  logic [511:0] src_b = '0;
  logic         busy, valid;
  logic [511:0] result;

  always #5 clk = ~clk;

  lsel_clmul u0 (.*);

  int total = 0, bad = 0, pcnt = 0, acc_cyc = 0, pushes = 0, pops = 0;
  logic [511:0] exp_q[$];
  logic prev_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference: iterate over the bits of the first operand
  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 64; i++) if (a[i]) r ^= ({64'd0, b} << i);
    return r;
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s1, input logic [511:0] s2,
                                         input logic [7:0] im, input logic [1:0] sel);
    logic [511:0] r = '0;
    int n = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 4;
    for (int l = 0; l < n; l++)
      r[l*128 +: 128] = ref_mul(s1[(2*l + im[0])*64 +: 64], s2[(2*l + im[4])*64 +: 64]);
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  always @(posedge clk) pcnt++;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected completion", result, '0);
        else begin
          logic [511:0] e;
          e = exp_q.pop_front();
          pops++;
          chk(result === e, "R1 R2 R3 product", result, e);
          chk(pcnt - acc_cyc == 64, "R7 latency", 512'(pcnt - acc_cyc), 512'd64);
          chk(!busy, "R7 busy low at completion", 512'(busy), '0);
          chk(!result[127] && !result[255] && !result[383] && !result[511], "R6 top bit",
              result, e);
        end
        if (prev_valid) chk(0, "R7 pulse width", 512'd2, 512'd1);
      end
      prev_valid = valid;
    end
  end

  task automatic issue(input logic [511:0] s1, input logic [511:0] s2,
                       input logic [7:0] im, input logic [1:0] sel);
    @(negedge clk);
    while (busy) @(negedge clk);
    src_a = s1; src_b = s2; imm = im; lane_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc_cyc = pcnt;
    exp_q.push_back(model(s1, s2, im, sel));
    pushes++;
    chk(busy, "R7 busy after accept", 512'(busy), 512'd1);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] a, b, keep;
    repeat (3) @(negedge clk);
    chk(!busy && !valid && result == '0, "R9 in reset", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !valid && result == '0, "R9 after reset", result, '0);

    // R3: 3 x 3 over GF(2) is 5
    issue({510'd0, 2'b11}, {510'd0, 2'b11}, 8'h00, 2'b00);
    wait_idle();
    chk(result == 512'd5, "R3 xor combine", result, 512'd5);

    // R1 R2: every selection on distinct quadwords
    a = rnd512(); b = rnd512();
    for (int s = 0; s < 4; s++) begin
      logic [7:0] im;
      im = {3'b000, s[1], 3'b000, s[0]};
      issue(a, b, im, 2'b10);
      wait_idle();
      chk(result == model(a, b, im, 2'b10), "R1 R2 selection", result, model(a, b, im, 2'b10));
    end

    // R4: all lane codes, inactive lanes zero
    for (int s = 0; s < 4; s++) begin
      issue(a, b, 8'h11, s[1:0]);
      wait_idle();
      chk(result == model(a, b, 8'h11, s[1:0]), "R4 lane count", result, model(a, b, 8'h11, s[1:0]));
    end

    // R5: other immediate bits ignored
    issue(a, b, 8'h00, 2'b11);
    wait_idle();
    keep = result;
    issue(a, b, 8'hEE, 2'b11);
    wait_idle();
    chk(result == keep, "R5 imm bits ignored", result, keep);

    // R6: all ones gives largest degree
    issue({512{1'b1}}, {512{1'b1}}, 8'h11, 2'b10);
    wait_idle();
    chk(!result[127] && result[126], "R6 bit 127 zero", result, model({512{1'b1}}, {512{1'b1}}, 8'h11, 2'b10));

    // R8: start while busy is ignored
    issue(a, b, 8'h01, 2'b10);
    repeat (10) @(negedge clk);
    src_a = rnd512(); src_b = rnd512(); imm = 8'h10; lane_sel = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    keep = result;
    repeat (80) @(negedge clk);
    chk(result == keep && !busy && pops == pushes, "R8 ignored start, result held", result, keep);

    // random traffic
    for (int t = 0; t < 40; t++) issue(rnd512(), rnd512(), 8'($urandom), 2'($urandom));
    wait_idle();
    chk(pops == pushes, "R7 completions match requests", 512'(pops), 512'(pushes));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule